// File: doc/BRIEF.md
# One-Wire Bus Master Controller

This block is a register-mapped master for several open-drain one-wire lines. Software writes one control word that picks a line, a speed (normal or overdrive) and an operation: a reset pulse with presence detection, a write-0 slot, a write-1 slot that also reads the line, a powered delay of about one millisecond, or an idle command that ends at once. The block then times the low pulses, samples the wire and reports the result through a status word. It can also raise an interrupt when the operation ends.

Time is counted in base periods. Each base period comes from a programmable clock divider. There is one divider value for normal speed and one for overdrive. For each line the block drives a pull-down enable and a strong-power enable, and it reads the wire back through a line input. A line is released, and so pulled high, whenever neither enable is set. The bus never stalls. Read data is a combinational view of the addressed register, and a read strobe at address 0 has one side effect: it clears the pending interrupt.

Top module: `owm_ctrl`

## Requirements
- R1: After reset the status word at address 0 reads 0, no pull-down or power enable is active, irq is low, and address 1 reads {overdrive divider default, normal divider default} in bits [31:16] and [15:0].
- R2: Command field bits [2:0] are {ovd, rst, dat}, and a command is taken only when bit 3 is 1. A reset cycle (rst=1, dat=0) pulls the selected line low for 96 base periods. Status bit 3 (busy) stays high for 192 periods. Status bit 0 then holds the wire level sampled at the end of period 110, so it reads 0 when a slave answered with a presence pulse and 1 when none did.
- R3: A write-0 cycle (rst=0, dat=0) pulls the line low for 12 periods in a 13-period slot, and bit 0 reads 0 afterwards.
- R4: A write-1 cycle (rst=0, dat=1) pulls the line low for 1 period in a 13-period slot. Bit 0 takes the wire level at the end of period 3, so it reads 1 with an idle wire and 0 when a slave holds the wire low.
- R5: A divider value d gives base periods of d+1 clocks. Address 1 holds the overdrive value in bits [31:16] and the normal value in bits [15:0]. Commands with ovd=1 use the overdrive value.
- R6: A delay command (ovd=0, rst=1, dat=1) pulls no line low, keeps busy high for DELAY_PERIODS normal periods, and leaves bit 0 unchanged.
- R7: An idle command (ovd=1, rst=1, dat=1) is always taken. It ends any running cycle, and busy reads 0 in the cycle after the write.
- R8: Each taken command latches the power enable (bit 4) and a per-line power mask (bits [16+N_LINES-1:16]). line_pwr[i] equals enable AND mask[i], forced off while that line is pulled low. Power stays on after the cycle ends and is cleared by a taken command with bit 4 at 0.
- R9: A non-idle command written while busy is ignored. The running cycle keeps its length, and the newly named line is never pulled low.
- R10: Bit 12 of a taken command enables the interrupt. When enabled, irq is set as a cycle completes, and a read strobe at address 0 clears it; if both happen in the same cycle, the set wins. With the enable at 0, irq stays low.
- R11: Only the line selected by bits [11:8] is ever pulled low, only while busy, and never while its power enable is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe; at address 0 clears the pending interrupt |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Word address: 0 control/status, 1 dividers |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Interrupt, high until cleared by a status read |
| line_pd | output | N_LINES | Per-line pull-down enable |
| line_pwr | output | N_LINES | Per-line strong-power enable |
| line_in | input | N_LINES | Per-line wire level |

## Verification
The assertions take two things for granted. Writes and read strobes are single-cycle pulses that are sampled at the clock edge. line_in is an asynchronous level that the block resynchronises itself. Slot timing also assumes divider values of at least 1, so that the two-flop input delay stays well inside a base period. The stimulus sets the dividers to 3 and 1. It keeps the modelled slave's presence and read-zero windows many clocks away from each sampling point. Every strobe is driven at the falling edge and lasts one cycle.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    K_RESET = 2'd0,
    K_WR0   = 2'd1,
    K_WR1   = 2'd2,
    K_DELAY = 2'd3
  } owm_kind_e;

  // slot timing in base periods
  localparam int RST_LOW_P  = 96;
  localparam int RST_TOT_P  = 192;
  localparam int RST_SAMP_P = 110;
  localparam int SLOT_TOT_P = 13;
  localparam int WR0_LOW_P  = 12;
  localparam int WR1_LOW_P  = 1;
  localparam int RD_SAMP_P  = 3;

  localparam logic [2:0] CMD_IDLE = 3'b111;

  function automatic owm_kind_e cmd_kind(input logic [2:0] c);
    case (c[1:0])
      2'b10:   cmd_kind = K_RESET;
      2'b00:   cmd_kind = K_WR0;
      2'b01:   cmd_kind = K_WR1;
      default: cmd_kind = K_DELAY;
    endcase
  endfunction

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick = run && (cnt_q == div);

  always_comb begin
    cnt_en = restart || run;
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int N_LINES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] raw,
  output logic [N_LINES-1:0] synced
);

  genvar gi;
  generate
    for (gi = 0; gi < N_LINES; gi++) begin : g_line
      logic meta_q, sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b1;
          sync_q <= 1'b1;
        end else begin
          meta_q <= raw[gi];
          sync_q <= meta_q;
        end
      end
      assign synced[gi] = sync_q;
    end
  endgenerate

endmodule

// File: rtl/owm_seq.sv
module owm_seq
  import owm_pkg::*;
#(
  parameter int DELAY_PERIODS = 200
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  owm_kind_e kind_in,
  input  logic      abort,
  input  logic      tick,
  input  logic      line_bit,
  output logic      busy,
  output logic      low,
  output logic      done,
  output logic      sample
);

  localparam int MAX_P = (DELAY_PERIODS > RST_TOT_P) ? DELAY_PERIODS : RST_TOT_P;
  localparam int PW    = $clog2(MAX_P + 1);

  logic            busy_q, busy_d;
  owm_kind_e       kind_q, kind_d;
  logic [PW-1:0]   pcnt_q, pcnt_d;
  logic            samp_q, samp_d;
  logic [PW-1:0]   low_len, tot_m1, samp_m1;
  logic            has_samp;

  always_comb begin
    case (kind_q)
      K_RESET: begin
        low_len = PW'(RST_LOW_P);  tot_m1 = PW'(RST_TOT_P - 1);
        samp_m1 = PW'(RST_SAMP_P - 1); has_samp = 1'b1;
      end
      K_WR0: begin
        low_len = PW'(WR0_LOW_P);  tot_m1 = PW'(SLOT_TOT_P - 1);
        samp_m1 = PW'(RD_SAMP_P - 1);  has_samp = 1'b1;
      end
      K_WR1: begin
        low_len = PW'(WR1_LOW_P);  tot_m1 = PW'(SLOT_TOT_P - 1);
        samp_m1 = PW'(RD_SAMP_P - 1);  has_samp = 1'b1;
      end
      default: begin
        low_len = '0;              tot_m1 = PW'(DELAY_PERIODS - 1);
        samp_m1 = '0;              has_samp = 1'b0;
      end
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    kind_d = kind_q;
    pcnt_d = pcnt_q;
    samp_d = samp_q;
    done   = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
      done   = 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      kind_d = kind_in;
      pcnt_d = '0;
    end else if (busy_q && tick) begin
      if (has_samp && (pcnt_q == samp_m1)) samp_d = line_bit;
      if (pcnt_q == tot_m1) begin
        busy_d = 1'b0;
        done   = 1'b1;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= K_WR1;
      pcnt_q <= '0;
      samp_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      kind_q <= kind_d;
      pcnt_q <= pcnt_d;
      samp_q <= samp_d;
    end
  end

  assign busy   = busy_q;
  assign low    = busy_q && (pcnt_q < low_len);
  assign sample = samp_q;

endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
  import owm_pkg::*;
#(
  parameter int          N_LINES       = 4,
  parameter int          DELAY_PERIODS = 200,
  parameter logic [15:0] DIV_N_RST     = 16'd29,
  parameter logic [15:0] DIV_O_RST     = 16'd5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic               bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq,
  output logic [N_LINES-1:0] line_pd,
  output logic [N_LINES-1:0] line_pwr,
  input  logic [N_LINES-1:0] line_in
);

  localparam int DIV_W  = 16;
  localparam int MASK_LO = 16;

  // control field positions
  localparam int B_START = 3;
  localparam int B_PWR   = 4;
  localparam int B_IEN   = 12;

  logic               wr_ctl, wr_div, rd_ctl;
  logic               is_idle, acc_idle, acc_run, acc_any;
  logic [3:0]         sel_q;
  logic               ovd_q, pwr_en_q, ien_q, irq_q, irq_d;
  logic [N_LINES-1:0] mask_q;
  logic [DIV_W-1:0]   div_n_q, div_o_q, div_sel;
  logic               seq_busy, seq_low, seq_done, seq_sample, tick;
  logic [N_LINES-1:0] line_s, hit;
  logic               sel_bit, ien_now;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata;

  // bus decode
  assign wr_ctl   = bus_wr && (bus_addr == 1'b0) && bus_wdata[B_START];
  assign wr_div   = bus_wr && (bus_addr == 1'b1);
  assign rd_ctl   = bus_rd && (bus_addr == 1'b0);
  assign is_idle  = (bus_wdata[2:0] == CMD_IDLE);
  assign acc_idle = wr_ctl && is_idle;
  assign acc_run  = wr_ctl && !is_idle && !seq_busy;
  assign acc_any  = acc_idle || acc_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      ovd_q    <= 1'b0;
      pwr_en_q <= 1'b0;
      ien_q    <= 1'b0;
      mask_q   <= '0;
    end else if (acc_any) begin
      sel_q    <= bus_wdata[11:8];
      ovd_q    <= bus_wdata[2];
      pwr_en_q <= bus_wdata[B_PWR];
      ien_q    <= bus_wdata[B_IEN];
      mask_q   <= bus_wdata[MASK_LO +: N_LINES];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_n_q <= DIV_N_RST;
      div_o_q <= DIV_O_RST;
    end else if (wr_div) begin
      div_n_q <= bus_wdata[15:0];
      div_o_q <= bus_wdata[31:16];
    end
  end

  // interrupt: completion sets, status read clears, set wins
  assign ien_now = acc_any ? bus_wdata[B_IEN] : ien_q;

  always_comb begin
    irq_d = irq_q;
    if (rd_ctl)              irq_d = 1'b0;
    if (seq_done && ien_now) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // time base
  assign div_sel = ovd_q ? div_o_q : div_n_q;

  owm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (acc_run),
    .run     (seq_busy),
    .div     (div_sel),
    .tick    (tick)
  );

  owm_sync #(.N_LINES(N_LINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (line_in),
    .synced (line_s)
  );

  // per-line drive
  genvar gi;
  generate
    for (gi = 0; gi < N_LINES; gi++) begin : g_drv
      assign hit[gi]      = (sel_q == 4'(gi));
      assign line_pd[gi]  = seq_low && hit[gi];
      assign line_pwr[gi] = pwr_en_q && mask_q[gi] && !line_pd[gi];
    end
  endgenerate

  assign sel_bit = (|(hit & line_s)) || !(|hit);

  owm_seq #(.DELAY_PERIODS(DELAY_PERIODS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (acc_run),
    .kind_in  (cmd_kind(bus_wdata[2:0])),
    .abort    (acc_idle),
    .tick     (tick),
    .line_bit (sel_bit),
    .busy     (seq_busy),
    .low      (seq_low),
    .done     (seq_done),
    .sample   (seq_sample)
  );

  // read mux
  always_comb begin
    if (bus_addr == 1'b1) begin
      bus_rdata = {div_o_q, div_n_q};
    end else begin
      bus_rdata         = '0;
      bus_rdata[0]      = seq_sample;
      bus_rdata[3]      = seq_busy;
      bus_rdata[4]      = pwr_en_q;
      bus_rdata[11:8]   = sel_q;
      bus_rdata[B_IEN]  = ien_q;
      bus_rdata[13]     = irq_q;
    end
  end

endmodule

// File: rtl/owm_ctrl_chk.sv
module owm_ctrl_chk #(
  parameter int N_LINES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic               bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               irq,
  input logic [N_LINES-1:0] line_pd,
  input logic [N_LINES-1:0] line_pwr,
  input logic               busy,
  input logic               done
);

  logic wr_start, wr_idle;
  assign wr_start = bus_wr && (bus_addr == 1'b0) && bus_wdata[3];
  assign wr_idle  = wr_start && (bus_wdata[2:0] == 3'b111);

  AST_PD_PWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pd & line_pwr) == '0); // R11

  AST_PD_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_pd)); // R11

  AST_PD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_pd) |-> busy); // R11

  AST_IDLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idle |=> !busy); // R7

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && wr_start && !wr_idle) |=> busy); // R9

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == 1'b0) && !done) |=> !irq); // R10

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done)); // R10

endmodule

bind owm_ctrl owm_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .line_pd   (line_pd),
  .line_pwr  (line_pwr),
  .busy      (seq_busy),
  .done      (seq_done)
);

// File: tb/owm_ctrl_bench.sv
module owm_ctrl_bench;

  localparam int NL     = 4;
  localparam int DLY_P  = 200;
  localparam int DN     = 3;
  localparam int DO     = 1;
  localparam int LIMIT  = 5000;

  typedef struct packed {
    logic [2:0] cmd;
    logic [3:0] sel;
    logic [1:0] mode;
    logic       bit_e;
    logic [7:0] low_p;
    logic [7:0] tot_p;
  } vec_t;

  // mode: 0 no slave, 1 presence responder, 2 read-zero responder
  localparam vec_t VEC [0:8] = '{
    '{3'b010, 4'd0, 2'd1, 1'b0, 8'd96, 8'd192},
    '{3'b010, 4'd1, 2'd0, 1'b1, 8'd96, 8'd192},
    '{3'b011, 4'd2, 2'd0, 1'b1, 8'd0,  8'd200},
    '{3'b000, 4'd2, 2'd0, 1'b0, 8'd12, 8'd13},
    '{3'b001, 4'd3, 2'd0, 1'b1, 8'd1,  8'd13},
    '{3'b001, 4'd1, 2'd2, 1'b0, 8'd1,  8'd13},
    '{3'b110, 4'd0, 2'd1, 1'b0, 8'd96, 8'd192},
    '{3'b101, 4'd2, 2'd2, 1'b0, 8'd1,  8'd13},
    '{3'b100, 4'd3, 2'd0, 1'b0, 8'd12, 8'd13}
  };

  logic          clk, rst_n;
  logic          bus_rd, bus_wr, bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          irq;
  logic [NL-1:0] line_pd, line_pwr, line_in;

  int n_chk, n_bad;
  int cur_sel, mode, pclk;
  int low_run, last_low, rel_cnt;
  logic slave_low;

  owm_ctrl #(
    .N_LINES       (NL),
    .DELAY_PERIODS (DLY_P),
    .DIV_N_RST     (16'd29),
    .DIV_O_RST     (16'd5)
  ) u_owm_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .line_pd   (line_pd),
    .line_pwr  (line_pwr),
    .line_in   (line_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // slave model on the selected line
  always @(posedge clk) begin
    if (line_pd[cur_sel]) begin
      low_run <= low_run + 1;
    end else begin
      if (low_run != 0) begin
        last_low <= low_run;
        rel_cnt  <= 0;
      end else begin
        rel_cnt <= rel_cnt + 1;
      end
      low_run <= 0;
    end
  end

  always_comb begin
    slave_low = 1'b0;
    if (mode == 1)
      slave_low = !line_pd[cur_sel] && (last_low >= 50*pclk) &&
                  (rel_cnt >= 4*pclk) && (rel_cnt <= 30*pclk);
    else if (mode == 2)
      slave_low = line_pd[cur_sel] ||
                  ((last_low < 50*pclk) && (last_low + rel_cnt < 6*pclk));
    for (int i = 0; i < NL; i++)
      line_in[i] = !(line_pd[i] || (slave_low && (i == cur_sel)));
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input logic [2:0] cmd, input logic [3:0] sel,
                                      input logic pwr, input logic [15:0] mask,
                                      input logic ien);
    return {mask, 3'b000, ien, sel, 3'b000, pwr, 1'b1, cmd};
  endfunction

  task automatic bus_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
  endtask

  task automatic run_cycle(output int nb, output int np);
    nb = 0; np = 0;
    while (bus_rdata[3] && nb < LIMIT) begin
      nb++;
      if (line_pd[cur_sel]) np++;
      @(negedge clk);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    cur_sel = 0; mode = 0; pclk = 30;
    low_run = 0; last_low = 0; rel_cnt = 0;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 status", bus_rdata, 32'h0);
    chk("R1 pd", 32'(line_pd), 32'h0);
    chk("R1 pwr", 32'(line_pwr), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    bus_addr = 1'b1; #1;
    chk("R1 dividers", bus_rdata, {16'd5, 16'd29});
    bus_addr = 1'b0;

    // R5: divider layout
    bus_write(1'b1, {16'(DO), 16'(DN)});
    bus_addr = 1'b1; #1;
    chk("R5 divider readback", bus_rdata, {16'(DO), 16'(DN)});
    bus_addr = 1'b0; #1;

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 9; v++) begin
      int nb, np;
      cur_sel = int'(VEC[v].sel);
      mode    = int'(VEC[v].mode);
      pclk    = VEC[v].cmd[2] ? DO + 1 : DN + 1;
      bus_write(1'b0, ctl(VEC[v].cmd, VEC[v].sel, 1'b0, 16'h0, 1'b0));
      run_cycle(nb, np);
      chk($sformatf("R2/R3/R4/R6 busy length vec%0d", v), nb, int'(VEC[v].tot_p) * pclk);
      chk($sformatf("R2/R3/R4/R5 low length vec%0d", v), np, int'(VEC[v].low_p) * pclk);
      chk($sformatf("R2/R4/R6 sampled bit vec%0d", v), 32'(bus_rdata[0]), 32'(VEC[v].bit_e));
      mode = 0;
      repeat (4) @(negedge clk);
    end
    chk("R10 irq off without enable", 32'(irq), 32'h0);

    // R9: non-idle write while busy is ignored
    begin
      int nb, p2;
      cur_sel = 0; mode = 1; pclk = DN + 1;
      bus_write(1'b0, ctl(3'b010, 4'd0, 1'b0, 16'h0, 1'b0));
      nb = 0; p2 = 0;
      while (bus_rdata[3] && nb < LIMIT) begin
        nb++;
        if (line_pd[2]) p2++;
        if (nb == 20) begin
          bus_wr = 1'b1; bus_wdata = ctl(3'b000, 4'd2, 1'b0, 16'h0, 1'b0);
        end else begin
          bus_wr = 1'b0; bus_wdata = '0;
        end
        @(negedge clk);
      end
      chk("R9 cycle length kept", nb, 192 * pclk);
      chk("R9 other line untouched", p2, 0);
      chk("R9 select kept", 32'(bus_rdata[11:8]), 32'd0);
      mode = 0;
    end

    // R7 + R8: idle aborts a powered delay, power held
    cur_sel = 1; pclk = DN + 1;
    bus_write(1'b0, ctl(3'b011, 4'd1, 1'b1, 16'h0002, 1'b0));
    repeat (40) @(negedge clk);
    chk("R6 delay busy", 32'(bus_rdata[3]), 32'h1);
    chk("R8 power during delay", 32'(line_pwr), 32'h2);
    bus_write(1'b0, ctl(3'b111, 4'd1, 1'b1, 16'h0002, 1'b0));
    chk("R7 idle ends busy", 32'(bus_rdata[3]), 32'h0);
    chk("R8 power kept after idle", 32'(line_pwr), 32'h2);

    // R8 + R11: power is gated off on the pulled line
    begin
      int nb, np;
      bus_write(1'b0, ctl(3'b000, 4'd1, 1'b1, 16'h0003, 1'b0));
      chk("R11 only selected pulled", 32'(line_pd), 32'h2);
      chk("R8 pwr gated on pulled line", 32'(line_pwr), 32'h1);
      run_cycle(nb, np);
      chk("R8 pwr after cycle", 32'(line_pwr), 32'h3);
      cur_sel = 0;
      bus_write(1'b0, ctl(3'b001, 4'd0, 1'b0, 16'h0003, 1'b0));
      chk("R8 pwr cleared", 32'(line_pwr), 32'h0);
      run_cycle(nb, np);
    end

    // R10: interrupt set and clear
    begin
      int nb, np;
      bus_write(1'b0, ctl(3'b001, 4'd0, 1'b0, 16'h0, 1'b1));
      chk("R10 irq low while busy", 32'(irq), 32'h0);
      run_cycle(nb, np);
      chk("R10 irq set at completion", 32'(irq), 32'h1);
      chk("R10 pending in status", 32'(bus_rdata[13]), 32'h1);
      @(negedge clk);
      bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      chk("R10 irq cleared by read", 32'(irq), 32'h0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule